// File: doc/BRIEF.md
# Register-Driven Bus Access Bridge

This block gives an 8-bit microcontroller a way to perform single reads and writes on a wider system bus with 32-bit addresses. Firmware sees a small window of 8-bit special function registers. It loads the target address and the write data one byte at a time. It then writes a control byte that holds the access width, the direction and a start bit. From the next cycle the start bit reads back as a busy flag. It stays at 1 while the bridge presents one request on a valid/ready master port and waits for the response. It drops to 0 on its own once the response has been taken. Firmware polls it and, after a read, collects the returned data from a read-back register.

The bridge works out the byte strobes from the access width and the low address bits. For writes it moves the data onto the matching byte lanes. For reads it moves the selected lanes down to bit 0 and fills the rest with zeros. Configuration writes are ignored while an access is in flight. An error response sets a sticky flag that firmware clears by writing 1 to it.

Control is a three-state machine:
- `BR_IDLE`: no access in flight. The launch transition to `BR_ISSUE` is taken on a control write with the start bit set.
- `BR_ISSUE`: the request is driven. The accept transition to `BR_AWAIT` is taken when ready is seen with valid.
- `BR_AWAIT`: the bridge waits for the response. The complete transition back to `BR_IDLE` is taken on a response valid.

Top module: `sfr_bus_bridge`

## Requirements
- R1: After reset every register reads 0 and `bus_req_valid` is 0.
- R2: Register index map, with multi-byte values least significant byte first: address at 0..3, write data at 4..7, read data at 8..11. Control is at 12, with bit0 = start/busy, bit1 = write direction and bits 3:2 = size. Status is at 13, with bit0 = error. Address, write data and control fields read back what was written.
- R3: A control write with bit0=1 and bit1=1 starts a write. From the next cycle `bus_req_valid`=1 and `bus_req_write`=1, and the request carries the programmed address.
- R4: A control write with bit0=1 and bit1=0 starts a read. An error-free response stores the selected lanes in the read-data register, shifted down to bit 0 and zero-extended. Write accesses leave the read-data register unchanged.
- R5: Control bit0 reads 1 from the cycle after the start write until the response is taken, and 0 from the cycle after the response.
- R6: While `bus_req_valid`=1 and `bus_req_ready`=0, valid, address, strobes, data and direction hold steady.
- R7: Size 0 is a byte, with strobe 1<<addr[1:0]. Size 1 is a halfword, with strobe 0011 for addr[1]=0 and 1100 for addr[1]=1; addr[0] is ignored. Sizes 2 and 3 are a word, with strobe 1111. Write data moves from bit 0 up to the first strobed lane.
- R8: Writes to the address, write-data and control registers are ignored while busy, including a start bit.
- R9: An error response sets status bit0 and leaves the read-data register unchanged. The bit stays set until status is written with bit0=1.
- R10: Each start produces exactly one request. `bus_req_valid` is 0 in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sfr_addr | input | SFR_AW | Register index for reads and writes |
| sfr_wr | input | 1 | Register write strobe |
| sfr_wdata | input | 8 | Register write byte |
| sfr_rdata | output | 8 | Register read byte (combinational from sfr_addr) |
| bus_req_valid | output | 1 | Request valid |
| bus_req_ready | input | 1 | Request accepted by the bus |
| bus_req_write | output | 1 | 1 = write, 0 = read |
| bus_req_addr | output | ADDR_W | Request address |
| bus_req_strb | output | DATA_W/8 | Byte-lane strobes |
| bus_req_wdata | output | DATA_W | Lane-aligned write data |
| bus_rsp_valid | input | 1 | Response valid (taken only while awaiting) |
| bus_rsp_data | input | DATA_W | Response read data |
| bus_rsp_err | input | 1 | Response carries an error |

## Verification
Some properties are checked on every cycle:
- Requests hold steady under backpressure.
- Only one request is issued per start.
- A byte access drives exactly one strobe, and the strobes always cover the addressed lane.
- The address and data registers are frozen while busy.
- The busy flag falls only after a response.
- The error flag is sticky.

Other behaviour can only be shown by the bench's scenarios:
- The exact lane placement and zero-extension for each size and offset.
- The byte order of the register window.
- That configuration writes and start bits issued during an access leave no trace.
- That an error response preserves the earlier read value.

// File: rtl/sfr_bridge_pkg.sv
package sfr_bridge_pkg;

    typedef enum logic [1:0] {
        BR_IDLE  = 2'd0,
        BR_ISSUE = 2'd1,
        BR_AWAIT = 2'd2
    } br_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } xfer_size_e;

    localparam int CTRL_FIRE_BIT = 0;
    localparam int CTRL_DIR_BIT  = 1;
    localparam int CTRL_SZ_LO    = 2;
    localparam int STAT_ERR_BIT  = 0;

endpackage

// File: rtl/sfr_bridge_lanes.sv
module sfr_bridge_lanes
    import sfr_bridge_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int LANES   = DATA_W / 8,
    parameter int LANE_AW = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LANE_AW-1:0] addr_low,
    input  xfer_size_e         size,
    input  logic [DATA_W-1:0]  wdata_in,
    input  logic [DATA_W-1:0]  bus_rdata,
    output logic [LANES-1:0]   strb,
    output logic [DATA_W-1:0]  wdata_out,
    output logic [DATA_W-1:0]  rdata_out
);

    int                sz_log;
    int                span;
    int                off;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        sz_log = int'(size);
        if (sz_log > LANE_AW) begin
            sz_log = LANE_AW;
        end
        span      = 1 << sz_log;
        off       = int'(addr_low) & ~(span - 1);
        shifted   = bus_rdata >> (8 * off);
        wdata_out = wdata_in << (8 * off);
        strb      = '0;
        rdata_out = '0;
        for (int i = 0; i < LANES; i++) begin
            strb[i] = (i >= off) && (i < off + span);
            if (i < span) begin
                rdata_out[8*i +: 8] = shifted[8*i +: 8];
            end
        end
    end

    // R7: a byte access drives exactly one lane
    a_r7_byte_strb: assert property (@(posedge clk) disable iff (!rst_n)
        (size == SZ_BYTE) |-> ($countones(strb) == 1));

    // R7: the addressed lane is always among the strobed lanes
    a_r7_lane_covered: assert property (@(posedge clk) disable iff (!rst_n)
        strb[addr_low] == 1'b1);

endmodule

// File: rtl/sfr_bridge_fsm.sv
module sfr_bridge_fsm
    import sfr_bridge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic req_ready,
    input  logic rsp_valid,
    input  logic rsp_err,
    output logic busy,
    output logic req_valid,
    output logic done,
    output logic done_err
);

    br_state_e state_q;
    br_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BR_IDLE:  if (launch)    state_d = BR_ISSUE;
            BR_ISSUE: if (req_ready) state_d = BR_AWAIT;
            BR_AWAIT: if (rsp_valid) state_d = BR_IDLE;
            default:                 state_d = BR_IDLE;
        endcase
    end

    always_comb begin
        busy      = 1'b0;
        req_valid = 1'b0;
        done      = 1'b0;
        done_err  = 1'b0;
        unique case (state_q)
            BR_IDLE: begin
            end
            BR_ISSUE: begin
                busy      = 1'b1;
                req_valid = 1'b1;
            end
            BR_AWAIT: begin
                busy     = 1'b1;
                done     = rsp_valid;
                done_err = rsp_valid && rsp_err;
            end
            default: begin
            end
        endcase
    end

    // R6: a request waiting for ready is not withdrawn
    a_r6_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> req_valid);

    // R10: one request per start
    a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_valid);

    // R5: busy only ends after a response
    a_r5_done_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(rsp_valid));

endmodule

// File: rtl/sfr_bridge_regs.sv
module sfr_bridge_regs
    import sfr_bridge_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SFR_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SFR_AW-1:0] sfr_addr,
    input  logic              sfr_wr,
    input  logic [7:0]        sfr_wdata,
    output logic [7:0]        sfr_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic              done_err,
    input  logic [DATA_W-1:0] rdata_in,
    output logic              launch,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output xfer_size_e        size_q,
    output logic              dir_q
);

    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int DATA_BYTES = DATA_W / 8;
    localparam int IDX_WDATA  = ADDR_BYTES;
    localparam int IDX_RDATA  = IDX_WDATA + DATA_BYTES;
    localparam int IDX_CTRL   = IDX_RDATA + DATA_BYTES;
    localparam int IDX_STAT   = IDX_CTRL + 1;

    logic [DATA_W-1:0] rdata_q;
    logic              err_q;
    logic              wr_ok;
    logic              ctrl_wr;
    logic              stat_wr;

    assign wr_ok   = sfr_wr && !busy;
    assign ctrl_wr = wr_ok && (sfr_addr == SFR_AW'(IDX_CTRL));
    assign stat_wr = sfr_wr && (sfr_addr == SFR_AW'(IDX_STAT));
    assign launch  = ctrl_wr && sfr_wdata[CTRL_FIRE_BIT];

    for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_addr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                addr_q[8*b +: 8] <= '0;
            end else if (wr_ok && sfr_addr == SFR_AW'(b)) begin
                addr_q[8*b +: 8] <= sfr_wdata;
            end
        end
    end

    for (genvar b = 0; b < DATA_BYTES; b++) begin : g_wdata
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wdata_q[8*b +: 8] <= '0;
            end else if (wr_ok && sfr_addr == SFR_AW'(IDX_WDATA + b)) begin
                wdata_q[8*b +: 8] <= sfr_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q <= SZ_BYTE;
            dir_q  <= 1'b0;
        end else if (ctrl_wr) begin
            size_q <= xfer_size_e'(sfr_wdata[CTRL_SZ_LO +: 2]);
            dir_q  <= sfr_wdata[CTRL_DIR_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (done && !done_err && !dir_q) begin
            rdata_q <= rdata_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (done_err) begin
            err_q <= 1'b1;
        end else if (stat_wr && sfr_wdata[STAT_ERR_BIT]) begin
            err_q <= 1'b0;
        end
    end

    always_comb begin
        sfr_rdata = '0;
        for (int b = 0; b < ADDR_BYTES; b++) begin
            if (sfr_addr == SFR_AW'(b)) sfr_rdata = addr_q[8*b +: 8];
        end
        for (int b = 0; b < DATA_BYTES; b++) begin
            if (sfr_addr == SFR_AW'(IDX_WDATA + b)) sfr_rdata = wdata_q[8*b +: 8];
            if (sfr_addr == SFR_AW'(IDX_RDATA + b)) sfr_rdata = rdata_q[8*b +: 8];
        end
        if (sfr_addr == SFR_AW'(IDX_CTRL)) sfr_rdata = {4'b0, size_q, dir_q, busy};
        if (sfr_addr == SFR_AW'(IDX_STAT)) sfr_rdata = {7'b0, err_q};
    end

    // R8: configuration is frozen during an access
    a_r8_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(addr_q) && $stable(wdata_q) && $stable(dir_q)));

    // R9: error flag only leaves 1 through a status write
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !sfr_wr) |=> err_q);

endmodule

// File: rtl/sfr_bus_bridge.sv
module sfr_bus_bridge
    import sfr_bridge_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SFR_AW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SFR_AW-1:0]     sfr_addr,
    input  logic                  sfr_wr,
    input  logic [7:0]            sfr_wdata,
    output logic [7:0]            sfr_rdata,
    output logic                  bus_req_valid,
    input  logic                  bus_req_ready,
    output logic                  bus_req_write,
    output logic [ADDR_W-1:0]     bus_req_addr,
    output logic [DATA_W/8-1:0]   bus_req_strb,
    output logic [DATA_W-1:0]     bus_req_wdata,
    input  logic                  bus_rsp_valid,
    input  logic [DATA_W-1:0]     bus_rsp_data,
    input  logic                  bus_rsp_err
);

    localparam int LANES   = DATA_W / 8;
    localparam int LANE_AW = $clog2(LANES);

    logic              busy;
    logic              launch;
    logic              done;
    logic              done_err;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_aligned;
    xfer_size_e        size_q;
    logic              dir_q;

    sfr_bridge_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SFR_AW (SFR_AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sfr_addr  (sfr_addr),
        .sfr_wr    (sfr_wr),
        .sfr_wdata (sfr_wdata),
        .sfr_rdata (sfr_rdata),
        .busy      (busy),
        .done      (done),
        .done_err  (done_err),
        .rdata_in  (rdata_aligned),
        .launch    (launch),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .size_q    (size_q),
        .dir_q     (dir_q)
    );

    sfr_bridge_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .req_ready (bus_req_ready),
        .rsp_valid (bus_rsp_valid),
        .rsp_err   (bus_rsp_err),
        .busy      (busy),
        .req_valid (bus_req_valid),
        .done      (done),
        .done_err  (done_err)
    );

    sfr_bridge_lanes #(
        .DATA_W  (DATA_W),
        .LANES   (LANES),
        .LANE_AW (LANE_AW)
    ) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_low  (addr_q[LANE_AW-1:0]),
        .size      (size_q),
        .wdata_in  (wdata_q),
        .bus_rdata (bus_rsp_data),
        .strb      (bus_req_strb),
        .wdata_out (bus_req_wdata),
        .rdata_out (rdata_aligned)
    );

    assign bus_req_addr  = addr_q;
    assign bus_req_write = dir_q;

    // R6: request payload holds under backpressure
    a_r6_payload_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_req_ready) |=>
            ($stable(bus_req_addr) && $stable(bus_req_strb) &&
             $stable(bus_req_wdata) && $stable(bus_req_write)));

endmodule

// File: tb/test_sfr_bus_bridge.sv
`timescale 1ns/1ps
module test_sfr_bus_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  sfr_addr = '0;
    logic        sfr_wr = 1'b0;
    logic [7:0]  sfr_wdata = '0;
    logic [7:0]  sfr_rdata;
    logic        bus_req_valid;
    logic        bus_req_ready = 1'b0;
    logic        bus_req_write;
    logic [31:0] bus_req_addr;
    logic [3:0]  bus_req_strb;
    logic [31:0] bus_req_wdata;
    logic        bus_rsp_valid = 1'b0;
    logic [31:0] bus_rsp_data = '0;
    logic        bus_rsp_err = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sfr_bus_bridge i_sfr_bus_bridge (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
        .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
        .bus_req_write(bus_req_write), .bus_req_addr(bus_req_addr),
        .bus_req_strb(bus_req_strb), .bus_req_wdata(bus_req_wdata),
        .bus_rsp_valid(bus_rsp_valid), .bus_rsp_data(bus_rsp_data),
        .bus_rsp_err(bus_rsp_err)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [31:0] addr;
        logic [31:0] wd;
        logic [31:0] brd;
        logic [3:0]  strb;
        logic [31:0] bwd;
        logic [31:0] rd;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd2, 32'h1000_0000, 32'hA5B6_C7D8, 32'h0,           4'hF, 32'hA5B6_C7D8, 32'h0},
        '{1'b1, 2'd0, 32'h2000_0003, 32'h0000_00EE, 32'h0,           4'h8, 32'hEE00_0000, 32'h0},
        '{1'b1, 2'd1, 32'h2000_0002, 32'h0000_1234, 32'h0,           4'hC, 32'h1234_0000, 32'h0},
        '{1'b0, 2'd2, 32'h3000_0004, 32'h0,         32'hDEAD_BEEF,   4'hF, 32'h0,         32'hDEAD_BEEF},
        '{1'b0, 2'd0, 32'h3000_0001, 32'h0,         32'h1122_3344,   4'h2, 32'h0,         32'h0000_0033},
        '{1'b0, 2'd1, 32'h3000_0002, 32'h0,         32'h5566_7788,   4'hC, 32'h0,         32'h0000_5566},
        '{1'b0, 2'd1, 32'h3000_0003, 32'h0,         32'hCAFE_F00D,   4'hC, 32'h0,         32'h0000_CAFE},
        '{1'b1, 2'd0, 32'h0000_0000, 32'h0000_007F, 32'h0,           4'h1, 32'h0000_007F, 32'h0},
        '{1'b0, 2'd3, 32'h0000_0040, 32'h0,         32'h0102_0304,   4'hF, 32'h0,         32'h0102_0304},
        '{1'b1, 2'd0, 32'h0000_0005, 32'h0000_0042, 32'h0,           4'h2, 32'h0000_4200, 32'h0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sfr_put(input int idx, input logic [7:0] val);
        @(negedge clk);
        sfr_addr  = 4'(idx);
        sfr_wdata = val;
        sfr_wr    = 1'b1;
        @(negedge clk);
        sfr_wr    = 1'b0;
    endtask

    task automatic sfr_get(input int idx, output logic [7:0] val);
        sfr_addr = 4'(idx);
        #0.5;
        val = sfr_rdata;
    endtask

    task automatic get32(input int base, output logic [31:0] val);
        logic [7:0] b;
        for (int k = 0; k < 4; k++) begin
            sfr_get(base + k, b);
            val[8*k +: 8] = b;
        end
    endtask

    task automatic load(input logic [31:0] a, input logic [31:0] d);
        for (int k = 0; k < 4; k++) sfr_put(k, a[8*k +: 8]);
        for (int k = 0; k < 4; k++) sfr_put(4 + k, d[8*k +: 8]);
    endtask

    // Completes an already started request: stall, accept, respond.
    task automatic finish_xfer(input int stall, input logic [31:0] brd, input logic berr);
        logic [7:0]  c;
        logic [31:0] a0;
        a0 = bus_req_addr;
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            check("R6 valid held", {31'b0, bus_req_valid}, 32'd1);
            check("R6 addr held", bus_req_addr, a0);
        end
        bus_req_ready = 1'b1;
        @(negedge clk);
        bus_req_ready = 1'b0;
        check("R10 valid after accept", {31'b0, bus_req_valid}, 32'd0);
        sfr_get(12, c);
        check("R5 busy while awaiting", {31'b0, c[0]}, 32'd1);
        bus_rsp_valid = 1'b1;
        bus_rsp_data  = brd;
        bus_rsp_err   = berr;
        @(negedge clk);
        bus_rsp_valid = 1'b0;
        bus_rsp_err   = 1'b0;
        sfr_get(12, c);
        check("R5 busy cleared", {31'b0, c[0]}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  c;
        logic [31:0] last_rd;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 req valid", {31'b0, bus_req_valid}, 32'd0);
        get32(0, v);  check("R1 addr", v, 32'h0);
        get32(4, v);  check("R1 wdata", v, 32'h0);
        get32(8, v);  check("R1 rdata", v, 32'h0);
        sfr_get(12, c); check("R1 ctrl", {24'b0, c}, 32'h0);
        sfr_get(13, c); check("R1 status", {24'b0, c}, 32'h0);

        last_rd = 32'h0;
        for (int i = 0; i < NV; i++) begin
            vec_t t;
            t = VECS[i];
            load(t.addr, t.wd);
            get32(0, v); check("R2 addr readback", v, t.addr);
            get32(4, v); check("R2 wdata readback", v, t.wd);
            sfr_put(12, {4'b0, t.sz, t.wr, 1'b1});
            check(t.wr ? "R3 write valid" : "R4 read valid", {31'b0, bus_req_valid}, 32'd1);
            check("R3 direction", {31'b0, bus_req_write}, {31'b0, t.wr});
            check("R3 address", bus_req_addr, t.addr);
            check("R7 strobes", {28'b0, bus_req_strb}, {28'b0, t.strb});
            if (t.wr) check("R7 write lanes", bus_req_wdata, t.bwd);
            sfr_get(12, c);
            check("R5 busy after start", {24'b0, c}, {24'b0, 4'b0, t.sz, t.wr, 1'b1});
            finish_xfer(i % 3, t.brd, 1'b0);
            if (!t.wr) last_rd = t.rd;
            get32(8, v);
            check(t.wr ? "R4 rdata kept on write" : "R4 rdata aligned", v, last_rd);
        end

        // R8: configuration writes ignored while busy
        load(32'h5000_0010, 32'h0);
        sfr_put(12, 8'h09);
        sfr_put(0, 8'hFF);
        sfr_put(4, 8'hAA);
        sfr_put(12, 8'h03);
        check("R8 addr port unchanged", bus_req_addr, 32'h5000_0010);
        check("R8 direction unchanged", {31'b0, bus_req_write}, 32'd0);
        finish_xfer(0, 32'h1357_2468, 1'b0);
        check("R8 no extra request", {31'b0, bus_req_valid}, 32'd0);
        get32(0, v); check("R8 addr reg unchanged", v, 32'h5000_0010);
        get32(4, v); check("R8 wdata reg unchanged", v, 32'h0);
        sfr_get(12, c); check("R8 ctrl unchanged", {24'b0, c}, 32'h08);
        get32(8, v); check("R4 read after lock test", v, 32'h1357_2468);

        // R9: sticky error, rdata preserved
        sfr_put(12, 8'h01);
        finish_xfer(1, 32'hFFFF_FFFF, 1'b1);
        sfr_get(13, c); check("R9 error set", {24'b0, c}, 32'h1);
        get32(8, v); check("R9 rdata kept on error", v, 32'h1357_2468);
        sfr_put(12, 8'h0B);
        finish_xfer(0, 32'h0, 1'b0);
        sfr_get(13, c); check("R9 error sticky", {24'b0, c}, 32'h1);
        sfr_put(13, 8'h00);
        sfr_get(13, c); check("R9 write 0 keeps error", {24'b0, c}, 32'h1);
        sfr_put(13, 8'h01);
        sfr_get(13, c); check("R9 write 1 clears", {24'b0, c}, 32'h0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule